// File: doc/BRIEF.md
# PTP system time generator

This block keeps a running time of day as a seconds word and a subseconds word, for a precision time protocol node. Software drives it through a small register write port. It can step the subseconds by a fixed increment on every clock (coarse mode). It can also drive that step from the carry-out of an addend accumulator (fine mode), so that a servo can trim the clock rate by rewriting the addend.

The counter is deliberately inert until software has both enabled it and loaded a start time. Loading a start time and loading a new addend are both one-shot control bits. Each reads back as set until the block has acted on it, so software can poll for completion. A compare against a programmed target time raises a sticky status bit. That bit reaches the interrupt pin unless a mask bit holds it back.

Top module: `ptp_time_gen`

## Requirements
- R1: After reset the seconds and subseconds outputs are 0, the interrupt output is 0, and reading the control register (address 0) returns 0.
- R2: Setting only the enable bit (control bit 0) does not start the counter: the time outputs keep their value until an initialize has happened.
- R3: Writing the control register with bits 0 and 2 set makes bit 2 read as 1 in the following cycle. One cycle after the write, the time is loaded from the seconds update register (address 3) and the subseconds update register (address 4), and bit 2 reads 0 again. If the same write has bit 0 clear, bit 2 is ignored: it reads 0 and the time is not loaded.
- R4: Writing control bit 5 makes it read as 1 for one cycle. The addend register (address 2) is then copied into the active addend, and bit 5 reads 0.
- R5: With control bit 1 clear (coarse mode), a running counter adds the increment register (address 1, low 8 bits) to the subseconds on every clock, starting one cycle after the load.
- R6: With control bit 1 set (fine mode), a running counter adds the active addend to a 32-bit accumulator on every clock. The subseconds advance by the increment only on the accumulator's carry-out.
- R7: The subseconds are 31 bits wide. When a step carries them to 2^31 or beyond, they keep only the low 31 bits and the seconds word increments by 1.
- R8: Writing control bit 0 as 0 stops the counter, and the time outputs hold. Setting enable again does not resume counting. A fresh initialize reloads the update registers and restarts the counter.
- R9: The trigger status (address 8, bit 0) becomes 1 one cycle after a running counter's time is at or past the target time (seconds at address 5, subseconds at address 6). It stays 1 until a write of 1 to address 8 bit 0 clears it.
- R10: The interrupt output equals the trigger status while mask bit 9 of address 7 is 0, and is 0 while that mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PTP reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address (control or status) |
| rd_data_o | output | 32 | Read data; 0 for addresses other than 0 and 8 |
| sec_o | output | 32 | Current seconds |
| subsec_o | output | 31 | Current subseconds |
| trig_irq_o | output | 1 | Target-time interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit seconds, 31-bit subseconds, an 8-bit increment and a 32-bit accumulator. With these widths the subsecond rollover is reached within one clock by preloading the subseconds just below 2^31. An addend of 2^30 gives exactly two accumulator carries in any eight clocks, so the fine-mode rate check does not depend on the accumulator's phase. A target a few cycles ahead of the preloaded time exercises the trigger, the mask and the clear within a short run.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  typedef enum logic [3:0] {
    A_CTRL    = 4'd0,
    A_INC     = 4'd1,
    A_ADDEND  = 4'd2,
    A_SEC_UPD = 4'd3,
    A_SUB_UPD = 4'd4,
    A_TGT_SEC = 4'd5,
    A_TGT_SUB = 4'd6,
    A_MASK    = 4'd7,
    A_STATUS  = 4'd8
  } reg_addr_e;

  localparam int CTRL_EN      = 0;
  localparam int CTRL_FINE    = 1;
  localparam int CTRL_INIT    = 2;
  localparam int CTRL_ADD_UPD = 5;
  localparam int MASK_TRIG    = 9;
  localparam int STS_TRIG     = 0;
endpackage

// File: rtl/ptp_regs.sv
module ptp_regs
  import ptp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int SUB_W  = 31,
  parameter int INC_W  = 8,
  parameter int ACC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              en_o,
  output logic              fine_o,
  output logic              init_pend_o,
  output logic              add_pend_o,
  output logic              run_o,
  output logic [INC_W-1:0]  inc_o,
  output logic [ACC_W-1:0]  addend_o,
  output logic [SEC_W-1:0]  upd_sec_o,
  output logic [SUB_W-1:0]  upd_sub_o,
  output logic [SEC_W-1:0]  tgt_sec_o,
  output logic [SUB_W-1:0]  tgt_sub_o,
  output logic              mask_o,
  output logic              sts_clr_o
);
  logic              en_q, fine_q, init_pend_q, add_pend_q, inited_q, mask_q;
  logic [INC_W-1:0]  inc_q;
  logic [ACC_W-1:0]  addend_q, addend_act_q;
  logic [SEC_W-1:0]  upd_sec_q, tgt_sec_q;
  logic [SUB_W-1:0]  upd_sub_q, tgt_sub_q;
  logic              wr_ctrl;

  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q         <= 1'b0;
      fine_q       <= 1'b0;
      init_pend_q  <= 1'b0;
      add_pend_q   <= 1'b0;
      inited_q     <= 1'b0;
      mask_q       <= 1'b0;
      inc_q        <= '0;
      addend_q     <= '0;
      addend_act_q <= '0;
      upd_sec_q    <= '0;
      upd_sub_q    <= '0;
      tgt_sec_q    <= '0;
      tgt_sub_q    <= '0;
    end else begin
      init_pend_q <= 1'b0;
      add_pend_q  <= 1'b0;
      if (add_pend_q)  addend_act_q <= addend_q;
      if (init_pend_q) inited_q     <= 1'b1;
      if (wr_en_i) begin
        case (reg_addr_e'(wr_addr_i))
          A_CTRL: begin
            en_q        <= wr_data_i[CTRL_EN];
            fine_q      <= wr_data_i[CTRL_FINE];
            init_pend_q <= wr_data_i[CTRL_INIT] & wr_data_i[CTRL_EN];
            add_pend_q  <= wr_data_i[CTRL_ADD_UPD];
            if (!wr_data_i[CTRL_EN]) inited_q <= 1'b0;
          end
          A_INC:     inc_q     <= wr_data_i[INC_W-1:0];
          A_ADDEND:  addend_q  <= wr_data_i[ACC_W-1:0];
          A_SEC_UPD: upd_sec_q <= wr_data_i[SEC_W-1:0];
          A_SUB_UPD: upd_sub_q <= wr_data_i[SUB_W-1:0];
          A_TGT_SEC: tgt_sec_q <= wr_data_i[SEC_W-1:0];
          A_TGT_SUB: tgt_sub_q <= wr_data_i[SUB_W-1:0];
          A_MASK:    mask_q    <= wr_data_i[MASK_TRIG];
          default: ;
        endcase
      end
    end
  end

  assign en_o        = en_q;
  assign fine_o      = fine_q;
  assign init_pend_o = init_pend_q;
  assign add_pend_o  = add_pend_q;
  assign run_o       = en_q && inited_q && !init_pend_q;
  assign inc_o       = inc_q;
  assign addend_o    = addend_act_q;
  assign upd_sec_o   = upd_sec_q;
  assign upd_sub_o   = upd_sub_q;
  assign tgt_sec_o   = tgt_sec_q;
  assign tgt_sub_o   = tgt_sub_q;
  assign mask_o      = mask_q;
  assign sts_clr_o   = wr_en_i && (wr_addr_i == A_STATUS) && wr_data_i[STS_TRIG];

  assert_init_selfclear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_pend_q && !wr_ctrl |=> !init_pend_q);
  assert_init_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_pend_q |-> en_q);
  assert_add_selfclear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_pend_q && !wr_ctrl |=> !add_pend_q);
  assert_disable_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && !wr_data_i[CTRL_EN] |=> !run_o);
endmodule

// File: rtl/ptp_accum.sv
module ptp_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fine_i,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, addend_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              acc_q <= '0;
    else if (clr_i)           acc_q <= '0;
    else if (run_i && fine_i) acc_q <= sum[ACC_W-1:0];
  end

  // coarse mode steps every clock
  assign tick_o = fine_i ? sum[ACC_W] : 1'b1;

  assert_acc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !(run_i && fine_i) |=> $stable(acc_q));
endmodule

// File: rtl/ptp_counter.sv
module ptp_counter #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int INC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic [SEC_W-1:0] upd_sec_i,
  input  logic [SUB_W-1:0] upd_sub_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o
);
  localparam int PAD_W = SUB_W + 1 - INC_W;

  logic [SEC_W-1:0] sec_q;
  logic [SUB_W-1:0] sub_q;
  logic [SUB_W:0]   nxt;

  assign nxt = {1'b0, sub_q} + {{PAD_W{1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (load_i) begin
      sec_q <= upd_sec_i;
      sub_q <= upd_sub_i;
    end else if (step_i) begin
      sub_q <= nxt[SUB_W-1:0];
      if (nxt[SUB_W]) sec_q <= sec_q + 1'b1;
    end
  end

  assign sec_o = sec_q;
  assign sub_o = sub_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !step_i |=> $stable(sec_q) && $stable(sub_q));
  assert_sec_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> (sec_q == $past(sec_q)) || (sec_q == SEC_W'($past(sec_q) + 1'b1)));
endmodule

// File: rtl/ptp_trigger.sv
module ptp_trigger #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [SEC_W-1:0] tgt_sec_i,
  input  logic [SUB_W-1:0] tgt_sub_i,
  input  logic             clr_i,
  input  logic             mask_i,
  output logic             sts_o,
  output logic             irq_o
);
  logic sts_q, reached;

  assign reached = {sec_i, sub_i} >= {tgt_sec_i, tgt_sub_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sts_q <= 1'b0;
    else if (clr_i)              sts_q <= 1'b0;
    else if (run_i && reached)   sts_q <= 1'b1;
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q & ~mask_i;

  assert_sts_needs_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q) |-> $past(run_i));
  assert_sts_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !sts_q);
endmodule

// File: rtl/ptp_time_gen.sv
module ptp_time_gen
  import ptp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int SUB_W  = 31,
  parameter int INC_W  = 8,
  parameter int ACC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [3:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic [SUB_W-1:0]  subsec_o,
  output logic              trig_irq_o
);
  logic             en, fine, init_pend, add_pend, run, mask, sts_clr, sts, tick;
  logic [INC_W-1:0] inc;
  logic [ACC_W-1:0] addend;
  logic [SEC_W-1:0] upd_sec, tgt_sec;
  logic [SUB_W-1:0] upd_sub, tgt_sub;

  ptp_regs #(.DATA_W(DATA_W), .SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .ACC_W(ACC_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en), .fine_o(fine), .init_pend_o(init_pend), .add_pend_o(add_pend), .run_o(run),
    .inc_o(inc), .addend_o(addend), .upd_sec_o(upd_sec), .upd_sub_o(upd_sub),
    .tgt_sec_o(tgt_sec), .tgt_sub_o(tgt_sub), .mask_o(mask), .sts_clr_o(sts_clr)
  );

  ptp_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i, .rst_ni, .run_i(run), .fine_i(fine), .clr_i(init_pend),
    .addend_i(addend), .tick_o(tick)
  );

  ptp_counter #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W)) u_counter (
    .clk_i, .rst_ni, .load_i(init_pend), .step_i(run && tick), .inc_i(inc),
    .upd_sec_i(upd_sec), .upd_sub_i(upd_sub), .sec_o, .sub_o(subsec_o)
  );

  ptp_trigger #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_trigger (
    .clk_i, .rst_ni, .run_i(run), .sec_i(sec_o), .sub_i(subsec_o),
    .tgt_sec_i(tgt_sec), .tgt_sub_i(tgt_sub), .clr_i(sts_clr), .mask_i(mask),
    .sts_o(sts), .irq_o(trig_irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (reg_addr_e'(rd_addr_i))
      A_CTRL: begin
        rd_data_o[CTRL_EN]      = en;
        rd_data_o[CTRL_FINE]    = fine;
        rd_data_o[CTRL_INIT]    = init_pend;
        rd_data_o[CTRL_ADD_UPD] = add_pend;
      end
      A_STATUS: rd_data_o[STS_TRIG] = sts;
      default: ;
    endcase
  end
endmodule

// File: tb/ptp_time_gen_tb.sv
module ptp_time_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] sec;
  logic [30:0] subsec;
  logic        irq;

  always #10 clk = ~clk;

  ptp_time_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .sec_o(sec), .subsec_o(subsec), .trig_irq_o(irq)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0, cmp_on = 1'b0;

  localparam longint unsigned M32 = 64'hFFFF_FFFF;
  localparam longint unsigned ROLL = 64'h8000_0000;

  bit m_en, m_fine, m_ip, m_ap, m_inited, m_sts, m_mask;
  longint unsigned m_inc, m_addend, m_aact, m_hi, m_lo, m_tsec, m_tsub, m_acc, m_sec, m_sub;

  // behavioural reference, stepped on each rising edge
  always @(posedge clk or negedge rst_n) begin : model
    bit run, tick, wc, reached;
    if (!rst_n) begin
      {m_en, m_fine, m_ip, m_ap, m_inited, m_sts, m_mask} = '0;
      m_inc = 0; m_addend = 0; m_aact = 0; m_hi = 0; m_lo = 0;
      m_tsec = 0; m_tsub = 0; m_acc = 0; m_sec = 0; m_sub = 0;
    end else begin
      run = m_en && m_inited && !m_ip;
      reached = (m_sec > m_tsec) || (m_sec == m_tsec && m_sub >= m_tsub);
      if (wr_en && wr_addr == 4'd8 && wr_data[0]) m_sts = 1'b0;
      else if (run && reached) m_sts = 1'b1;
      tick = m_fine ? (((m_acc + m_aact) >> 32) != 0) : 1'b1;
      if (m_ip) begin
        m_sec = m_hi; m_sub = m_lo; m_acc = 0;
      end else if (run) begin
        if (m_fine) m_acc = (m_acc + m_aact) & M32;
        if (tick) begin
          m_sub = m_sub + m_inc;
          if (m_sub >= ROLL) begin
            m_sub = m_sub - ROLL;
            m_sec = (m_sec + 1) & M32;
          end
        end
      end
      if (m_ap) m_aact = m_addend;
      wc = wr_en && wr_addr == 4'd0;
      if (wc && !wr_data[0]) m_inited = 1'b0;
      else if (m_ip) m_inited = 1'b1;
      m_ip = wc && wr_data[2] && wr_data[0];
      m_ap = wc && wr_data[5];
      if (wc) begin m_en = wr_data[0]; m_fine = wr_data[1]; end
      if (wr_en) begin
        case (wr_addr)
          4'd1: m_inc = longint'(wr_data[7:0]);
          4'd2: m_addend = longint'(wr_data);
          4'd3: m_hi = longint'(wr_data);
          4'd4: m_lo = longint'(wr_data[30:0]);
          4'd5: m_tsec = longint'(wr_data);
          4'd6: m_tsub = longint'(wr_data[30:0]);
          4'd7: m_mask = wr_data[9];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R5 R6 R7 seconds vs model", sec, m_sec);
      chk("R5 R6 R7 subseconds vs model", subsec, m_sub);
      chk("R10 irq vs model", irq, m_sts && !m_mask);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    longint unsigned s0, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    // R1 reset state
    chk("R1 seconds", sec, 0);
    chk("R1 subseconds", subsec, 0);
    chk("R1 irq", irq, 0);
    rd(4'd0, v); chk("R1 control read", v, 0);

    // R2 enable alone does not count
    wr(4'd1, 32'd5);
    wr(4'd4, 32'd100);
    wr(4'd3, 32'd7);
    wr(4'd5, 32'd10);
    wr(4'd6, 32'h100);
    wr(4'd7, 32'h200);
    wr(4'd0, 32'h1);
    repeat (5) @(negedge clk);
    chk("R2 seconds held", sec, 0);
    chk("R2 subseconds held", subsec, 0);
    rd(4'd8, v); chk("R9 status before target", v[0], 0);

    // R3 initialize
    wr(4'd0, 32'h5);
    rd(4'd0, v); chk("R3 init bit pending", v[2], 1);
    @(negedge clk);
    chk("R3 seconds loaded", sec, 7);
    chk("R3 subseconds loaded", subsec, 100);
    rd(4'd0, v); chk("R3 init bit cleared", v[2], 0);
    @(negedge clk);
    chk("R5 first coarse step", subsec, 105);
    repeat (10) @(negedge clk);
    chk("R5 ten coarse steps", subsec, 155);

    // R4 / R6 addend load and fine mode
    wr(4'd2, 32'h4000_0000);
    wr(4'd0, 32'h23);
    rd(4'd0, v); chk("R4 addend bit pending", v[5], 1);
    @(negedge clk);
    rd(4'd0, v); chk("R4 addend bit cleared", v[5], 0);
    s0 = subsec;
    repeat (8) @(negedge clk);
    chk("R6 two carries in eight clocks", subsec - s0, 10);

    // R7 rollover
    wr(4'd1, 32'h10);
    wr(4'd3, 32'd9);
    wr(4'd4, 32'h7FFF_FFF0);
    wr(4'd0, 32'h5);
    @(negedge clk);
    chk("R7 seconds preload", sec, 9);
    chk("R7 subseconds preload", subsec, 32'h7FFF_FFF0);
    @(negedge clk);
    chk("R7 seconds incremented", sec, 10);
    chk("R7 subseconds wrapped", subsec, 0);

    // R9 / R10 trigger, mask, clear
    repeat (20) @(negedge clk);
    rd(4'd8, v); chk("R9 status set at target", v[0], 1);
    chk("R10 irq masked", irq, 0);
    wr(4'd7, 32'h0);
    chk("R10 irq unmasked", irq, 1);
    wr(4'd5, 32'hFFFF);
    wr(4'd8, 32'h1);
    rd(4'd8, v); chk("R9 status cleared", v[0], 0);
    repeat (3) @(negedge clk);
    rd(4'd8, v); chk("R9 status stays clear", v[0], 0);
    chk("R10 irq follows clear", irq, 0);

    // R8 disable and re-init
    wr(4'd0, 32'h0);
    s0 = subsec; t0 = sec;
    repeat (5) @(negedge clk);
    chk("R8 subseconds stopped", subsec, s0);
    chk("R8 seconds stopped", sec, t0);
    wr(4'd0, 32'h4);
    rd(4'd0, v); chk("R3 init ignored while disabled", v[2], 0);
    repeat (3) @(negedge clk);
    chk("R3 no load while disabled", subsec, s0);
    wr(4'd0, 32'h1);
    repeat (5) @(negedge clk);
    chk("R8 re-enable alone stays stopped", subsec, s0);
    wr(4'd0, 32'h5);
    @(negedge clk);
    chk("R8 reload seconds", sec, 9);
    chk("R8 reload subseconds", subsec, 32'h7FFF_FFF0);
    @(negedge clk);
    chk("R8 counting resumed", sec, 10);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule